// File: doc/BRIEF.md
# Vectored Interrupt Message Controller

The block gathers 64 interrupt lines and turns each qualifying one into a message on a valid/ready output. Every line goes through a two-flop synchronizer. It is then configured as edge or level sensitive and as active-high/rising or active-low/falling. A line must be both unmasked and message-enabled before it may send. Each outgoing message carries that line's programmable 8-bit vector byte, its 8-bit route byte and its index.

Software reaches the configuration through a simple register bus. The bus takes 64-bit, 32-bit and 8-bit accesses, and read data is combinational on the address. Per-line control bits sit in two 32-bit banks per group: line n lives in bank n/32 at bit n%32, and the two banks are 4 bytes apart. A 64-bit access to a group covers both banks, with bank 1 in bits 63:32. The route and vector bytes have one byte address per line. A read-only identification word reports the line count.

Top module: `irq_msg_ctrl`

## Requirements
- R1: After reset the mask group reads all ones. The message-enable, edge, polarity, both spare groups and every route byte read zero. Vector byte n reads n, and no message is valid.
- R2: A 64-bit read at offset 0x000 returns 64'h003F_0000_0000_0000, with the line count minus one in bits 55:48. A 32-bit read at 0x004 returns 32'h003F_0000. Writes to these addresses change nothing.
- R3: The group offsets are mask 0x020, message-enable 0x040, edge 0x060, clear 0x080, spare A 0x0C0, spare B 0x0E0 and polarity 0x3E0. A 32-bit access at group+4*b reaches bank b. A 64-bit access at the group offset reaches both banks, with bank 1 in bits 63:32.
- R4: Byte accesses at 0x100+n reach the route byte of line n, and byte accesses at 0x200+n reach its vector byte. The message carries both bytes as they were when it was launched.
- R5: A level line with polarity 0 is active while its input is high. It sends one message, and sends again only after the input has gone low and then high again.
- R6: A level line with polarity 1 is active while its input is low, with the same single-send rule as R5.
- R7: An edge line with polarity 0 latches an event on a rising input and sends one message. It sends nothing more until a 1 is written to its clear bit. Clear bits written as 0 have no effect, and the clear group reads zero.
- R8: An edge line with polarity 1 latches an event on a falling input.
- R9: A line whose mask bit is 1, or whose message-enable bit is 0, sends nothing. A pending level line sends once it is unmasked.
- R10: When several lines qualify at once, the lowest index is sent first, then the next lowest.
- R11: While valid is high and ready is low, the vector, route and index stay unchanged. Each accepted message is followed by at least one cycle with valid low.
- R12: The spare groups are plain read/write storage and have no effect on messages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | 64 | Asynchronous interrupt lines |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 2 | 0 = byte, 1 = 32-bit, 2 = 64-bit |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 64 | Write data, right-aligned |
| bus_rdata_o | output | 64 | Read data, right-aligned, combinational on address and size |
| msg_valid_o | output | 1 | Message present |
| msg_ready_i | input | 1 | Receiver accepts the message |
| msg_vector_o | output | 8 | Vector byte of the sent line |
| msg_route_o | output | 8 | Route byte of the sent line |
| msg_src_o | output | 6 | Index of the sent line |

## Verification
Some properties are checked by assertions on every cycle. Message fields hold while the receiver stalls, and a bubble follows each handshake. A launched message came from a line that qualified in the previous cycle, and no lower-indexed line qualified in that cycle. An edge event is latched only after an active transition. The bench scenarios cover what needs stimulus history: the register map and reset values, the four sense modes, the single-send rule with its re-arm conditions, the masking, the clear, and the order of two lines released together.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;
  localparam int NSRC   = 64;
  localparam int BANK_W = 32;
  localparam int IW     = $clog2(NSRC);
  localparam int BW     = 8;

  localparam logic [1:0] SZ_B = 2'd0;
  localparam logic [1:0] SZ_W = 2'd1;
  localparam logic [1:0] SZ_D = 2'd2;

  // group offsets as 8-byte slot indices (addr[11:3])
  localparam logic [8:0] G_ID   = 9'h000;
  localparam logic [8:0] G_MASK = 9'h004;
  localparam logic [8:0] G_EN   = 9'h008;
  localparam logic [8:0] G_EDGE = 9'h00C;
  localparam logic [8:0] G_CLR  = 9'h010;
  localparam logic [8:0] G_AUTA = 9'h018;
  localparam logic [8:0] G_AUTB = 9'h01C;
  localparam logic [8:0] G_POL  = 9'h07C;

  localparam logic [3:0] PG_ROUTE = 4'h1;
  localparam logic [3:0] PG_VEC   = 4'h2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int N = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] in_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] acc_i,
  output logic [N-1:0] elig_o
);
  logic [N-1:0] act, act_q, rise, pend_q, sent_q, src_on;

  assign act    = in_i ^ pol_i;
  assign rise   = act & ~act_q;
  assign src_on = (edge_i & pend_q) | (~edge_i & act);
  assign elig_o = src_on & ~mask_i & en_i & ~sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      pend_q <= '0;
      sent_q <= '0;
    end else begin
      act_q  <= act;
      // new event wins over a clear in the same cycle
      pend_q <= (pend_q & ~clr_i) | (rise & edge_i);
      // re-arm: explicit clear, or level line going inactive
      sent_q <= (sent_q | acc_i) & ~clr_i & ~(~edge_i & ~act);
    end
  end

  AST_EDGE_NEEDS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_q & ~$past(pend_q)) & ~$past(rise & edge_i)) == '0); // R7
endmodule

// File: rtl/irq_pick.sv
module irq_pick
  import irq_msg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] elig_i,
  input  logic [BW-1:0]   vec_i   [NSRC],
  input  logic [BW-1:0]   route_i [NSRC],
  input  logic            ready_i,
  output logic            valid_o,
  output logic [BW-1:0]   vec_o,
  output logic [BW-1:0]   route_o,
  output logic [IW-1:0]   src_o,
  output logic [NSRC-1:0] acc_o
);
  logic [IW-1:0]   sel;
  logic            any;
  logic [NSRC-1:0] low_mask;

  always_comb begin
    sel = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig_i[i]) sel = IW'(i);
    end
  end
  assign any = |elig_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      vec_o   <= '0;
      route_o <= '0;
      src_o   <= '0;
    end else if (!valid_o) begin
      if (any) begin
        valid_o <= 1'b1;
        vec_o   <= vec_i[sel];
        route_o <= route_i[sel];
        src_o   <= sel;
      end
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end

  assign acc_o    = (valid_o && ready_i) ? (NSRC'(1) << src_o) : '0;
  assign low_mask = (NSRC'(1) << src_o) - NSRC'(1);

  AST_HOLD_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(vec_o) && $stable(route_o) && $stable(src_o)); // R11
  AST_BUBBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && ready_i |=> !valid_o); // R11
  AST_LAUNCH_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (($past(elig_i) >> src_o) & NSRC'(1)) == NSRC'(1)); // R9
  AST_LOWEST_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> ($past(elig_i) & low_mask) == '0); // R10
endmodule

// File: rtl/irq_msg_ctrl.sv
module irq_msg_ctrl
  import irq_msg_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] irq_i,
  input  logic            bus_req_i,
  input  logic            bus_we_i,
  input  logic [1:0]      bus_size_i,
  input  logic [11:0]     bus_addr_i,
  input  logic [63:0]     bus_wdata_i,
  output logic [63:0]     bus_rdata_o,
  output logic            msg_valid_o,
  input  logic            msg_ready_i,
  output logic [BW-1:0]   msg_vector_o,
  output logic [BW-1:0]   msg_route_o,
  output logic [IW-1:0]   msg_src_o
);
  localparam logic [63:0] ID_WORD = 64'(NSRC - 1) << 48;

  logic [NSRC-1:0] mask_q, en_q, edge_q, pol_q, auta_q, autb_q;
  logic [BW-1:0]   vec_q   [NSRC];
  logic [BW-1:0]   route_q [NSRC];
  logic [NSRC-1:0] irq_s, elig, acc, clr;
  logic [8:0]      slot;
  logic            bank, wr_ok, byte_wr, idx_ok;
  logic [IW-1:0]   bidx;
  logic [63:0]     sel64;

  assign slot    = bus_addr_i[11:3];
  assign bank    = bus_addr_i[2];
  assign wr_ok   = bus_req_i && bus_we_i &&
                   ((bus_size_i == SZ_D && bus_addr_i[2:0] == 3'd0) ||
                    (bus_size_i == SZ_W && bus_addr_i[1:0] == 2'd0));
  assign idx_ok  = bus_addr_i[7:0] < 8'(NSRC);
  assign bidx    = bus_addr_i[IW-1:0];
  assign byte_wr = bus_req_i && bus_we_i && bus_size_i == SZ_B && idx_ok;

  function automatic logic [NSRC-1:0] merge(input logic [NSRC-1:0] old,
                                            input logic [63:0] wd,
                                            input logic [1:0] sz, input logic b);
    if (sz == SZ_D)  return wd[NSRC-1:0];
    else if (b)      return {wd[BANK_W-1:0], old[BANK_W-1:0]};
    else             return {old[NSRC-1:BANK_W], wd[BANK_W-1:0]};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      en_q   <= '0;
      edge_q <= '0;
      pol_q  <= '0;
      auta_q <= '0;
      autb_q <= '0;
    end else if (wr_ok) begin
      case (slot)
        G_MASK:  mask_q <= merge(mask_q, bus_wdata_i, bus_size_i, bank);
        G_EN:    en_q   <= merge(en_q,   bus_wdata_i, bus_size_i, bank);
        G_EDGE:  edge_q <= merge(edge_q, bus_wdata_i, bus_size_i, bank);
        G_POL:   pol_q  <= merge(pol_q,  bus_wdata_i, bus_size_i, bank);
        G_AUTA:  auta_q <= merge(auta_q, bus_wdata_i, bus_size_i, bank);
        G_AUTB:  autb_q <= merge(autb_q, bus_wdata_i, bus_size_i, bank);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSRC; i++) begin
        vec_q[i]   <= BW'(i);
        route_q[i] <= '0;
      end
    end else if (byte_wr) begin
      if (bus_addr_i[11:8] == PG_ROUTE) route_q[bidx] <= bus_wdata_i[BW-1:0];
      if (bus_addr_i[11:8] == PG_VEC)   vec_q[bidx]   <= bus_wdata_i[BW-1:0];
    end
  end

  assign clr = (wr_ok && slot == G_CLR) ? merge('0, bus_wdata_i, bus_size_i, bank) : '0;

  always_comb begin
    case (slot)
      G_ID:    sel64 = ID_WORD;
      G_MASK:  sel64 = mask_q;
      G_EN:    sel64 = en_q;
      G_EDGE:  sel64 = edge_q;
      G_POL:   sel64 = pol_q;
      G_AUTA:  sel64 = auta_q;
      G_AUTB:  sel64 = autb_q;
      default: sel64 = '0;
    endcase
    bus_rdata_o = '0;
    if (bus_size_i == SZ_D && bus_addr_i[2:0] == 3'd0) begin
      bus_rdata_o = sel64;
    end else if (bus_size_i == SZ_W && bus_addr_i[1:0] == 2'd0) begin
      bus_rdata_o = {32'd0, bank ? sel64[63:32] : sel64[31:0]};
    end else if (bus_size_i == SZ_B && idx_ok) begin
      if (bus_addr_i[11:8] == PG_ROUTE) bus_rdata_o = {56'd0, route_q[bidx]};
      else if (bus_addr_i[11:8] == PG_VEC) bus_rdata_o = {56'd0, vec_q[bidx]};
    end
  end

  irq_sync #(.W(NSRC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (irq_s)
  );

  irq_detect #(.N(NSRC)) u_detect (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (irq_s),
    .pol_i (pol_q),
    .edge_i(edge_q),
    .mask_i(mask_q),
    .en_i  (en_q),
    .clr_i (clr),
    .acc_i (acc),
    .elig_o(elig)
  );

  irq_pick u_pick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .elig_i (elig),
    .vec_i  (vec_q),
    .route_i(route_q),
    .ready_i(msg_ready_i),
    .valid_o(msg_valid_o),
    .vec_o  (msg_vector_o),
    .route_o(msg_route_o),
    .src_o  (msg_src_o),
    .acc_o  (acc)
  );

  AST_MASKED_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |-> ((($past(mask_q) | ~$past(en_q)) >> msg_src_o) & NSRC'(1)) == '0); // R9
endmodule

// File: tb/irq_msg_ctrl_bench.sv
`timescale 1ns/100ps
module irq_msg_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  sz = 2'd0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic [63:0] rdata;
  logic        mvalid, mready = 1'b0;
  logic [7:0]  mvec, mroute;
  logic [5:0]  msrc;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_msg_ctrl u_irq_msg_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .bus_req_i(req), .bus_we_i(we), .bus_size_i(sz), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .msg_valid_o(mvalid), .msg_ready_i(mready),
    .msg_vector_o(mvec), .msg_route_o(mroute), .msg_src_o(msrc)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; sz = s; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, input logic [11:0] a, output logic [63:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; sz = s; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic setbit(input logic [11:0] g, input int n, input logic v);
    logic [63:0] t;
    rd(2'd2, g, t);
    t[n] = v;
    wr(2'd2, g, t);
  endtask

  task automatic expect_msg(input string tag, input int src, input logic [7:0] vec,
                            input logic [7:0] route);
    bit got = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (mvalid) begin got = 1'b1; break; end
    end
    chk({tag, " valid"}, 64'(got), 64'd1);
    if (got) begin
      chk({tag, " src"}, 64'(msrc), 64'(src));
      chk({tag, " vector"}, 64'(mvec), 64'(vec));
      chk({tag, " route"}, 64'(mroute), 64'(route));
    end
  endtask

  task automatic accept();
    mready = 1'b1;
    @(negedge clk);
    mready = 1'b0;
  endtask

  task automatic expect_quiet(input string tag, input int cycles);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (mvalid) seen = 1'b1;
    end
    chk({tag, " no message"}, 64'(seen), 64'd0);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    chk("R1 valid", 64'(mvalid), 64'd0);
    rd(2'd2, 12'h020, d); chk("R1 mask", d, '1);
    rd(2'd2, 12'h040, d); chk("R1 enable", d, '0);
    rd(2'd2, 12'h060, d); chk("R1 edge", d, '0);
    rd(2'd2, 12'h3E0, d); chk("R1 polarity", d, '0);
    rd(2'd2, 12'h0C0, d); chk("R1 spare A", d, '0);
    rd(2'd0, 12'h205, d); chk("R1 vector 5", d, 64'd5);
    rd(2'd0, 12'h23F, d); chk("R1 vector 63", d, 64'd63);
    rd(2'd0, 12'h127, d); chk("R1 route 39", d, 64'd0);
  endtask

  task automatic t_id();
    logic [63:0] d;
    rd(2'd2, 12'h000, d); chk("R2 id 64", d, 64'h003F_0000_0000_0000);
    rd(2'd1, 12'h004, d); chk("R2 id hi 32", d, 64'h003F_0000);
    wr(2'd2, 12'h000, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(2'd2, 12'h000, d); chk("R2 id after write", d, 64'h003F_0000_0000_0000);
  endtask

  task automatic t_layout();
    logic [63:0] d;
    wr(2'd1, 12'h044, 64'h0000_0100);
    rd(2'd2, 12'h040, d); chk("R3 bank1 bit8 is line 40", d, 64'h0000_0100_0000_0000);
    rd(2'd1, 12'h040, d); chk("R3 bank0 untouched", d, 64'd0);
    wr(2'd1, 12'h3E0, 64'h8000_0001);
    rd(2'd2, 12'h3E0, d); chk("R3 polarity bank0", d, 64'h0000_0000_8000_0001);
    wr(2'd2, 12'h3E0, 64'd0);
    rd(2'd1, 12'h3E0, d); chk("R3 polarity restored", d, 64'd0);
  endtask

  task automatic t_bytes();
    logic [63:0] d;
    wr(2'd0, 12'h128, 64'h5A);
    wr(2'd0, 12'h228, 64'hC3);
    rd(2'd0, 12'h128, d); chk("R4 route 40", d, 64'h5A);
    rd(2'd0, 12'h228, d); chk("R4 vector 40", d, 64'hC3);
    rd(2'd0, 12'h229, d); chk("R4 vector 41 untouched", d, 64'd41);
  endtask

  task automatic t_level_high();
    setbit(12'h020, 40, 1'b0);
    @(negedge clk); irq[40] = 1'b1;
    expect_msg("R5 level high", 40, 8'hC3, 8'h5A);
    repeat (3) @(negedge clk);
    chk("R11 held valid", 64'(mvalid), 64'd1);
    chk("R11 held vector", 64'(mvec), 64'hC3);
    wr(2'd0, 12'h228, 64'h11);
    chk("R4 launched vector kept", 64'(mvec), 64'hC3);
    accept();
    chk("R11 bubble after accept", 64'(mvalid), 64'd0);
    expect_quiet("R5 single send", 8);
    irq[40] = 1'b0;
    repeat (5) @(negedge clk);
    irq[40] = 1'b1;
    expect_msg("R5 resend after re-arm", 40, 8'h11, 8'h5A);
    accept();
    irq[40] = 1'b0;
    expect_quiet("R5 inactive", 6);
  endtask

  task automatic t_level_low();
    setbit(12'h3E0, 3, 1'b1);
    setbit(12'h040, 3, 1'b1);
    setbit(12'h020, 3, 1'b0);
    expect_msg("R6 active low", 3, 8'd3, 8'd0);
    accept();
    expect_quiet("R6 single send", 6);
    irq[3] = 1'b1;
    expect_quiet("R6 high is inactive", 6);
    irq[3] = 1'b0;
    expect_msg("R6 resend", 3, 8'd3, 8'd0);
    accept();
    irq[3] = 1'b1;
    expect_quiet("R6 idle", 4);
  endtask

  task automatic pulse(input int n);
    @(negedge clk); irq[n] = ~irq[n];
    repeat (3) @(negedge clk);
    irq[n] = ~irq[n];
  endtask

  task automatic t_edge_rise();
    logic [63:0] d;
    setbit(12'h060, 10, 1'b1);
    setbit(12'h040, 10, 1'b1);
    setbit(12'h020, 10, 1'b0);
    expect_quiet("R7 no event yet", 6);
    pulse(10);
    expect_msg("R7 rising edge", 10, 8'd10, 8'd0);
    accept();
    expect_quiet("R7 single send", 8);
    pulse(10);
    expect_quiet("R7 blocked until clear", 8);
    wr(2'd2, 12'h080, 64'h800);
    expect_quiet("R7 zero bits no effect", 6);
    rd(2'd2, 12'h080, d); chk("R7 clear reads zero", d, 64'd0);
    wr(2'd1, 12'h080, 64'h400);
    expect_quiet("R7 cleared, nothing pending", 6);
    pulse(10);
    expect_msg("R7 edge after clear", 10, 8'd10, 8'd0);
    accept();
  endtask

  task automatic t_edge_fall();
    irq[33] = 1'b1;
    repeat (4) @(negedge clk);
    setbit(12'h3E0, 33, 1'b1);
    setbit(12'h060, 33, 1'b1);
    setbit(12'h040, 33, 1'b1);
    setbit(12'h020, 33, 1'b0);
    expect_quiet("R8 high is idle", 6);
    irq[33] = 1'b0;
    expect_msg("R8 falling edge", 33, 8'd33, 8'd0);
    accept();
    irq[33] = 1'b1;
    expect_quiet("R8 rising ignored", 6);
    setbit(12'h020, 33, 1'b1);
  endtask

  task automatic t_mask();
    setbit(12'h040, 50, 1'b1);
    irq[50] = 1'b1;
    expect_quiet("R9 masked", 8);
    setbit(12'h020, 50, 1'b0);
    expect_msg("R9 unmasked", 50, 8'd50, 8'd0);
    accept();
    setbit(12'h020, 51, 1'b0);
    irq[51] = 1'b1;
    expect_quiet("R9 not enabled", 8);
    irq[50] = 1'b0; irq[51] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_priority();
    logic [63:0] d;
    setbit(12'h040, 7, 1'b1);
    setbit(12'h040, 20, 1'b1);
    irq[7] = 1'b1; irq[20] = 1'b1;
    repeat (4) @(negedge clk);
    rd(2'd2, 12'h020, d);
    d[7] = 1'b0; d[20] = 1'b0;
    wr(2'd2, 12'h020, d);
    expect_msg("R10 lowest first", 7, 8'd7, 8'd0);
    accept();
    expect_msg("R10 next", 20, 8'd20, 8'd0);
    accept();
    irq[7] = 1'b0; irq[20] = 1'b0;
    expect_quiet("R10 done", 6);
  endtask

  task automatic t_spare();
    logic [63:0] d;
    wr(2'd2, 12'h0C0, 64'hDEAD_BEEF_0123_4567);
    rd(2'd2, 12'h0C0, d); chk("R12 spare A", d, 64'hDEAD_BEEF_0123_4567);
    wr(2'd1, 12'h0E4, 64'hA5A5_A5A5);
    rd(2'd2, 12'h0E0, d); chk("R12 spare B bank1", d, 64'hA5A5_A5A5_0000_0000);
    expect_quiet("R12 no message", 8);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_id();
    t_layout();
    t_bytes();
    t_level_high();
    t_level_low();
    t_edge_rise();
    t_edge_fall();
    t_mask();
    t_priority();
    t_spare();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule